// File: doc/BRIEF.md
# Field Sequence and Sync Timebase

This block keeps the horizontal and vertical timebase of a composite video encoder. A sample counter runs across each line, a line counter runs across each field, and a 3-bit field sequence counter steps once per field. The line length follows a standard-select input (1716 clocks for 60 Hz, 1728 for 50 Hz), and the field length follows the same input.

An external source may supply horizontal and vertical reference pulses. A horizontal pulse ends the current line; a vertical pulse starts a new field. When the pulses stop, for any number of lines or fields, the counters keep running at their own nominal lengths. Pulses are not qualified: the environment must supply them only at sensible phases.

A single sync output carries one of several meanings chosen by a mode input: a vertical sync every field, an odd/even frame marker, or a sequence marker that pulses only on the first field of a 4- or 8-field cycle. The field sequence count is also brought out directly for status reads.

Top module: `field_timebase`

## Requirements
- R1: With no reference pulse, `sample_o` increments by one each clock and returns to 0 after reaching the line length minus one; the line length is LINE_LEN_50 when `std50_i`=1 and LINE_LEN_60 when `std50_i`=0. Wrap uses "at or beyond last sample", so a standard change mid-line never runs past the new length.
- R2: Each time the sample counter wraps, `line_o` increments; after FIELD_LINES_50 (`std50_i`=1) or FIELD_LINES_60 lines it returns to 0 and the field sequence advances.
- R3: A clock with `href_i`=1 (and `vref_i`=0) acts as an end of line: next cycle `sample_o`=0 and the line counter steps as in R2.
- R4: A clock with `vref_i`=1 makes `sample_o`=0 and `line_o`=0 next cycle and advances the field sequence by one; it takes priority over `href_i`.
- R5: When reference pulses are missing, for any number of lines or fields, the counters continue as in R1 and R2 without stopping.
- R6: The field sequence `fseq_o` advances modulo 4 when `fise_i`=1 (bit 2 forced to 0 on the step) and modulo 8 when `fise_i`=0; it changes only when the next state is sample 0, line 0. Bit 0 is 0 for odd fields and 1 for even fields.
- R7: With `mode_i`=2'b00, `sync_o` is 1 exactly while `line_o` < VSYNC_LINES, in every field.
- R8: With `mode_i`=2'b01, `sync_o` equals bit 0 of `fseq_o` (0 odd, 1 even).
- R9: With `mode_i`=2'b10, `sync_o` is 1 only while `line_o` < VSYNC_LINES and `fseq_o`=0, so once every 4 or 8 fields; with `mode_i`=2'b11, `sync_o` is 0.
- R10: While `rst_ni`=0, `sample_o`, `line_o` and `fseq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| std50_i | input | 1 | 1 selects 50 Hz line and field lengths, 0 selects 60 Hz |
| fise_i | input | 1 | 1: 4-field sequence, 0: 8-field sequence |
| mode_i | input | 2 | Sync output meaning: 00 field vsync, 01 odd/even, 10 sequence marker, 11 off |
| href_i | input | 1 | External horizontal reference pulse |
| vref_i | input | 1 | External vertical reference pulse |
| sample_o | output | SAMPLE_W | Sample position in line |
| line_o | output | LINE_W | Line position in field |
| fseq_o | output | 3 | Field sequence count |
| sync_o | output | 1 | Mode-selected sync/sequence output |

## Verification
The bench runs long free-running stretches in both standards and both sequence lengths, which separates the wrap points of the sample, line and field counters and the modulo-4 versus modulo-8 step. Horizontal pulses arriving early in the line, and vertical pulses in the middle of a field or together with a horizontal pulse, show the reload paths and their priority; stopping the pulses afterwards shows that the timebase keeps running. Each output mode is held across several full sequences so the per-field, odd/even and once-per-sequence patterns are told apart.

// File: rtl/field_timebase_pkg.sv
package field_timebase_pkg;
  typedef enum logic [1:0] {
    SYNC_FIELD   = 2'b00,
    SYNC_ODDEVEN = 2'b01,
    SYNC_SEQ     = 2'b10,
    SYNC_OFF     = 2'b11
  } sync_mode_e;

  localparam int unsigned SEQ_W = 3;

  function automatic logic [SEQ_W-1:0] seq_step(input logic [SEQ_W-1:0] cur, input logic short4);
    logic [SEQ_W-1:0] nxt;
    nxt = cur + 1'b1;
    if (short4) nxt[SEQ_W-1] = 1'b0;
    return nxt;
  endfunction
endpackage

// File: rtl/ftb_sample_ctr.sv
module ftb_sample_ctr #(
  parameter int unsigned LEN_A = 1716,
  parameter int unsigned LEN_B = 1728,
  parameter int unsigned W     = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_b_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] LAST_A = W'(LEN_A - 1);
  localparam logic [W-1:0] LAST_B = W'(LEN_B - 1);

  logic [W-1:0] last;
  assign last   = sel_b_i ? LAST_B : LAST_A;
  assign wrap_o = (cnt_o >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i || wrap_o)   cnt_o <= '0;
    else                        cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ftb_line_ctr.sv
module ftb_line_ctr #(
  parameter int unsigned LINES_A = 262,
  parameter int unsigned LINES_B = 312,
  parameter int unsigned W       = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_b_i,
  input  logic         step_i,
  input  logic         zero_i,
  output logic [W-1:0] cnt_o,
  output logic         eof_o
);
  localparam logic [W-1:0] LAST_A = W'(LINES_A - 1);
  localparam logic [W-1:0] LAST_B = W'(LINES_B - 1);

  logic [W-1:0] last;
  assign last  = sel_b_i ? LAST_B : LAST_A;
  assign eof_o = step_i && !zero_i && (cnt_o >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_o <= '0;
    else if (zero_i || eof_o)  cnt_o <= '0;
    else if (step_i)           cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ftb_seq_ctr.sv
module ftb_seq_ctr
  import field_timebase_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             short4_i,
  output logic [SEQ_W-1:0] seq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seq_o <= '0;
    else if (adv_i) seq_o <= seq_step(seq_o, short4_i);
  end
endmodule

// File: rtl/ftb_sync_sel.sv
module ftb_sync_sel
  import field_timebase_pkg::*;
#(
  parameter int unsigned VSYNC_LINES = 3,
  parameter int unsigned W           = 9
) (
  input  logic [1:0]       mode_i,
  input  logic [W-1:0]     line_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic             sync_o
);
  localparam logic [W-1:0] VS_END = W'(VSYNC_LINES);

  logic in_vs;
  assign in_vs = (line_i < VS_END);

  always_comb begin
    unique case (sync_mode_e'(mode_i))
      SYNC_FIELD:   sync_o = in_vs;
      SYNC_ODDEVEN: sync_o = seq_i[0];
      SYNC_SEQ:     sync_o = in_vs && (seq_i == '0);
      default:      sync_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/field_timebase.sv
module field_timebase
  import field_timebase_pkg::*;
#(
  parameter int unsigned LINE_LEN_60    = 1716,
  parameter int unsigned LINE_LEN_50    = 1728,
  parameter int unsigned FIELD_LINES_60 = 262,
  parameter int unsigned FIELD_LINES_50 = 312,
  parameter int unsigned VSYNC_LINES    = 3,
  localparam int unsigned SAMPLE_W = $clog2((LINE_LEN_50 > LINE_LEN_60) ? LINE_LEN_50 : LINE_LEN_60),
  localparam int unsigned LINE_W   = $clog2((FIELD_LINES_50 > FIELD_LINES_60) ? FIELD_LINES_50 : FIELD_LINES_60)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                std50_i,
  input  logic                fise_i,
  input  logic [1:0]          mode_i,
  input  logic                href_i,
  input  logic                vref_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [LINE_W-1:0]   line_o,
  output logic [SEQ_W-1:0]    fseq_o,
  output logic                sync_o
);
  logic s_wrap, line_step, eof;

  ftb_sample_ctr #(.LEN_A(LINE_LEN_60), .LEN_B(LINE_LEN_50), .W(SAMPLE_W)) u_sample (
    .clk_i, .rst_ni, .sel_b_i(std50_i), .clr_i(href_i || vref_i),
    .cnt_o(sample_o), .wrap_o(s_wrap)
  );

  // vertical reference overrides the line step
  assign line_step = href_i || s_wrap;

  ftb_line_ctr #(.LINES_A(FIELD_LINES_60), .LINES_B(FIELD_LINES_50), .W(LINE_W)) u_line (
    .clk_i, .rst_ni, .sel_b_i(std50_i), .step_i(line_step), .zero_i(vref_i),
    .cnt_o(line_o), .eof_o(eof)
  );

  ftb_seq_ctr u_seq (
    .clk_i, .rst_ni, .adv_i(vref_i || eof), .short4_i(fise_i), .seq_o(fseq_o)
  );

  ftb_sync_sel #(.VSYNC_LINES(VSYNC_LINES), .W(LINE_W)) u_sync (
    .mode_i, .line_i(line_o), .seq_i(fseq_o), .sync_o
  );
endmodule

// File: rtl/field_timebase_chk.sv
module field_timebase_chk #(
  parameter int unsigned LINE_LEN_60 = 1716,
  parameter int unsigned LINE_LEN_50 = 1728,
  parameter int unsigned SAMPLE_W    = 11,
  parameter int unsigned LINE_W      = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                std50_i,
  input logic                href_i,
  input logic                vref_i,
  input logic [1:0]          mode_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic [LINE_W-1:0]   line_o,
  input logic [2:0]          fseq_o,
  input logic                sync_o
);
  logic [SAMPLE_W-1:0] last;
  assign last = std50_i ? SAMPLE_W'(LINE_LEN_50 - 1) : SAMPLE_W'(LINE_LEN_60 - 1);

  assert_free_run_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!href_i && !vref_i && sample_o < last) |=> (sample_o == $past(sample_o) + 1'b1));

  assert_vref_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vref_i |=> (sample_o == '0 && line_o == '0));

  assert_href_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    href_i |=> (sample_o == '0));

  assert_seq_at_field_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fseq_o) |-> (sample_o == '0 && line_o == '0));

  assert_seq_marker_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && sync_o) |-> (fseq_o == 3'd0));

  assert_off_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |-> !sync_o);
endmodule

bind field_timebase field_timebase_chk #(
  .LINE_LEN_60(LINE_LEN_60), .LINE_LEN_50(LINE_LEN_50),
  .SAMPLE_W(SAMPLE_W), .LINE_W(LINE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .std50_i(std50_i), .href_i(href_i), .vref_i(vref_i),
  .mode_i(mode_i), .sample_o(sample_o), .line_o(line_o), .fseq_o(fseq_o), .sync_o(sync_o)
);

// File: tb/field_timebase_test.sv
`timescale 1ns/1ps
module field_timebase_test;
  localparam int L60 = 10, L50 = 12, F60 = 6, F50 = 7, VS = 2;
  localparam int SW = $clog2(L50), LW = $clog2(F50);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic std50_i = 1'b0, fise_i = 1'b1, href_i = 1'b0, vref_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [SW-1:0] sample_o;
  logic [LW-1:0] line_o;
  logic [2:0] fseq_o;
  logic sync_o;

  int n_tests = 0, n_fail = 0;
  int m_s = 0, m_l = 0, m_f = 0;
  bit last_h = 0, last_v = 0, free_phase = 0, done = 0;

  always #2.5 clk_i = ~clk_i;

  field_timebase #(.LINE_LEN_60(L60), .LINE_LEN_50(L50), .FIELD_LINES_60(F60),
                   .FIELD_LINES_50(F50), .VSYNC_LINES(VS)) uut (
    .clk_i, .rst_ni, .std50_i, .fise_i, .mode_i, .href_i, .vref_i,
    .sample_o, .line_o, .fseq_o, .sync_o);

  function automatic int adv(int f, bit f4);
    return f4 ? (f + 1) % 4 : (f + 1) % 8;
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s = 0; m_l = 0; m_f = 0; last_h = 0; last_v = 0;
    end else begin
      int len, fl;
      len = std50_i ? L50 : L60;
      fl  = std50_i ? F50 : F60;
      last_v = vref_i; last_h = href_i && !vref_i;
      if (vref_i) begin
        m_s = 0; m_l = 0; m_f = adv(m_f, fise_i);
      end else if (href_i || m_s >= len - 1) begin
        m_s = 0;
        if (m_l >= fl - 1) begin m_l = 0; m_f = adv(m_f, fise_i); end
        else m_l = m_l + 1;
      end else m_s = m_s + 1;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_sync();
    case (mode_i)
      2'b00: return (m_l < VS) ? 1 : 0;
      2'b01: return m_f % 2;
      2'b10: return (m_l < VS && m_f == 0) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      string st, lt, syt;
      st  = last_v ? "R4" : last_h ? "R3" : free_phase ? "R5" : "R1";
      lt  = last_v ? "R4" : free_phase ? "R5" : "R2";
      syt = (mode_i == 2'b00) ? "R7" : (mode_i == 2'b01) ? "R8" : "R9";
      check(int'(sample_o) == m_s, {st, " sample"}, int'(sample_o), m_s);
      check(int'(line_o) == m_l, {lt, " line"}, int'(line_o), m_l);
      check(int'(fseq_o) == m_f, "R6 fseq", int'(fseq_o), m_f);
      check(int'(sync_o) == exp_sync(), {syt, " sync"}, int'(sync_o), exp_sync());
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_h();
    @(negedge clk_i); href_i = 1'b1; @(negedge clk_i); href_i = 1'b0;
  endtask

  task automatic pulse_v();
    @(negedge clk_i); vref_i = 1'b1; @(negedge clk_i); vref_i = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    #12;
    check(sample_o == '0 && line_o == '0 && fseq_o == '0, "R10 reset state",
          int'(sample_o) + int'(line_o) + int'(fseq_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    // 60 Hz, 4-field, per-field vsync
    run(300);
    // 50 Hz, odd/even
    std50_i = 1'b1; mode_i = 2'b01; run(400);
    // 8-field sequence marker
    fise_i = 1'b0; mode_i = 2'b10; run(800);
    // back to 4-field in the middle of the sequence
    std50_i = 1'b0; fise_i = 1'b1; run(500);
    // early and on-time horizontal pulses
    mode_i = 2'b00;
    for (int i = 0; i < 20; i++) begin run(3 + i % 7); pulse_h(); end
    // vertical pulses mid-field, and together with href
    for (int i = 0; i < 6; i++) begin
      run(17 + 5 * i); pulse_v();
    end
    @(negedge clk_i); vref_i = 1'b1; href_i = 1'b1; @(negedge clk_i); vref_i = 1'b0; href_i = 1'b0;
    // pulses stop: timebase must keep running
    free_phase = 1; std50_i = 1'b1; fise_i = 1'b0; mode_i = 2'b10; run(1000);
    free_phase = 0;
    // off mode and a standard change mid-line
    mode_i = 2'b11; run(5); std50_i = 1'b0; run(200);
    mode_i = 2'b01; run(200);
    finish_run();
  end
endmodule